// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block sits between a host's configuration access port and the transmit side of a PCIe root port. A host access arrives as one word: target bus, device/function, register offset, size (1, 2 or 4 bytes), direction and write data. The block turns that access into a configuration request of three header dwords and, for writes, one data dword. It sends these as 64-bit beats, each marked with start-of-packet and end-of-packet flags. The low 32 bits of a beat hold the earlier dword and the high 32 bits hold the later one.

Some accesses must never reach the link. The block rejects these itself and answers at once. It also keeps its own copy of the root bus number. This copy picks between Type 0 and Type 1 requests and forms the requester ID. It is updated when the host writes the root port's primary bus register. Only one access is in flight at a time. After the last beat, the block waits for a completion result on a valid/error/data input. It then gives the requester a one-cycle response that carries a status and, for reads, the selected bytes.

Top module: `cfg_pkt_builder`

## Requirements
- R1: The format/type byte is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write. Type 0 is chosen when the target bus equals the tracked root bus number. The root bus number resets to 0.
- R2: Header dword 0 is {format/type, 24'd1}. Header dword 1 is {root bus, 8'h00, tag, byte enables}. The tag is 0x1D for a read and 0x10 for a write.
- R3: Header dword 2 is {bus, device/function, 16-bit offset with bits [1:0] cleared}.
- R4: Size code 0 is one byte and gives byte enables 0x01 shifted left by offset[1:0]. Size code 1 is two bytes and gives 0x03 shifted left by offset[1:0]. Any other code is four bytes and gives 0x0F. The data dword is the write data, masked to the access size, shifted left by 8*offset[1:0] and truncated to 32 bits.
- R5: Beat 1 is {hdr1, hdr0} with SOP set. A write with offset[2:0]==0 sends {0, hdr2} with no flags, then {0, data} with EOP. Any other write sends {data, hdr2} with EOP. A read sends {0, hdr2} with EOP.
- R6: An access to the root bus with device/function 0 and offset 0x10 sends no beats and answers with status 2 (bad register).
- R7: An access sends no beats and answers with status 1 (not found) in any of these cases: the device number (devfn[7:3]) is above 0 and the bus is the root bus; the device number is above 0 and the supplied primary bus equals the root bus; the bus is not the root bus and the link is down. A rejected read answers data 0xFFFFFFFF.
- R8: A write to the root bus at offset 0x18 whose completion has no error sets the root bus number to the low byte of the data dword. A write whose completion reports an error leaves the root bus number unchanged.
- R9: Only one access is outstanding. reqReady stays low from acceptance until the response. The response strobe lasts one cycle.
- R10: A completion without error gives status 0. A read then returns the completion data shifted right by 8*offset[1:0] and masked to 8 bits (size 0), shifted right by 8*(offset[1:0]&2) and masked to 16 bits (size 1), or whole (four bytes). A completion with error gives status 1, with read data 0xFFFFFFFF. Write responses carry data 0. A beat held by a low txReady keeps its data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link is in its active state |
| reqValid | input | 1 | Host access present |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqDevFn | input | 8 | Device (bits 7:3) and function (bits 2:0) |
| reqOffset | input | OFF_W | Register byte offset |
| reqSize | input | 2 | 0 = one byte, 1 = two bytes, other = four bytes |
| reqWdata | input | 32 | Write value, right-aligned |
| reqPrimaryBus | input | 8 | Primary bus of the target bus's bridge |
| txValid | output | 1 | Beat valid |
| txReady | input | 1 | Beat accepted |
| txData | output | 64 | Beat payload, earlier dword in bits 31:0 |
| txSop | output | 1 | First beat of a request |
| txEop | output | 1 | Last beat of a request |
| cplValid | input | 1 | Completion result present |
| cplError | input | 1 | Completion reported a failure |
| cplData | input | 32 | Completion data dword |
| rspValid | output | 1 | One-cycle response strobe |
| rspStatus | output | 2 | 0 ok, 1 not found, 2 bad register |
| rspData | output | 32 | Read result |

## Verification
A wrong root bus copy shows up on the very next request. It appears as the wrong format/type byte in beat 1 and as a wrong requester ID byte. It also shows up in which accesses are filtered. The bench therefore follows every write to the primary bus register with accesses to both the old and the new root bus. A misplaced beat-count decision shows within the same request: a flag is missing or stray, or the data sits in the wrong lane. A stuck state in the control appears as a missing response or as reqReady rising early. The sweeps cover every size, every offset inside a quad-word, both directions and random backpressure.

// File: rtl/cfgpkt_pkg.sv
package cfgpkt_pkg;
  localparam int DW     = 32;
  localparam int BEAT_W = 2 * DW;

  localparam logic [1:0] STS_OK       = 2'd0;
  localparam logic [1:0] STS_NOTFOUND = 2'd1;
  localparam logic [1:0] STS_BADREG   = 2'd2;

  localparam logic [7:0] FMT_RD_T0 = 8'h04;
  localparam logic [7:0] FMT_WR_T0 = 8'h44;
  localparam logic [7:0] FMT_RD_T1 = 8'h05;
  localparam logic [7:0] FMT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD    = 8'h1D;
  localparam logic [7:0] TAG_WR    = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RESP} ctrlState_e;

  typedef struct packed {
    logic       capture;
    logic       loadReject;
    logic       loadCpl;
    logic [1:0] beatSel;
  } strobe_t;
endpackage

// File: rtl/cfgpkt_ctrl.sv
module cfgpkt_ctrl
  import cfgpkt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] rejectCode,
  input  logic       threeBeats,
  output logic       txValid,
  input  logic       txReady,
  input  logic       cplValid,
  output logic       rspValid,
  output strobe_t    stb
);
  ctrlState_e state, stateNext;
  logic [1:0] beatIdx, beatIdxNext;
  logic       lastBeat;
  logic       accept;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign lastBeat = (beatIdx == 2'd2) || ((beatIdx == 2'd1) && !threeBeats);

  always_comb begin
    stateNext      = state;
    beatIdxNext    = beatIdx;
    stb            = '0;
    stb.beatSel    = beatIdx;
    reqReady       = (state == ST_IDLE);
    txValid        = (state == ST_SEND);
    rspValid       = (state == ST_RESP);
    case (state)
      ST_IDLE: if (accept) begin
        stb.capture = 1'b1;
        beatIdxNext = 2'd0;
        if (rejectCode != STS_OK) begin
          stb.loadReject = 1'b1;
          stateNext      = ST_RESP;
        end else begin
          stateNext = ST_SEND;
        end
      end
      ST_SEND: if (txReady) begin
        if (lastBeat) stateNext = ST_WAIT;
        else          beatIdxNext = beatIdx + 2'd1;
      end
      ST_WAIT: if (cplValid) begin
        stb.loadCpl = 1'b1;
        stateNext   = ST_RESP;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatIdx <= 2'd0;
    end else begin
      state   <= stateNext;
      beatIdx <= beatIdxNext;
    end
  end

  // R9: response strobe is a single cycle
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6 / R7: a filtered access goes straight to a response with no beat
  p_reject_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && rejectCode != STS_OK) |=> (!txValid && rspValid));
endmodule

// File: rtl/cfgpkt_datapath.sv
module cfgpkt_datapath
  import cfgpkt_pkg::*;
#(
  parameter int         OFF_W      = 12,
  parameter logic [7:0] ROOT_RESET = 8'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              linkUp,
  input  logic              reqWrite,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqSize,
  input  logic [DW-1:0]     reqWdata,
  input  logic [7:0]        reqPrimaryBus,
  input  logic              cplError,
  input  logic [DW-1:0]     cplData,
  output logic [1:0]        rejectCode,
  output logic              threeBeats,
  output logic [BEAT_W-1:0] beatData,
  output logic              beatSop,
  output logic              beatEop,
  output logic [1:0]        rspStatus,
  output logic [DW-1:0]     rspData
);
  localparam logic [15:0] BAR0_OFF     = 16'h0010;
  localparam logic [15:0] PRIM_BUS_OFF = 16'h0018;

  logic [7:0]    rootBusQ;
  logic [DW-1:0] hdr0Q, hdr1Q, hdr2Q, payloadQ;
  logic          writeQ, rootCfgQ;
  logic [1:0]    offLoQ, sizeQ;
  logic [1:0]    rspStatusQ;
  logic [DW-1:0] rspDataQ;

  logic [15:0]   offWide;
  logic          rootHit, devNonZero;
  logic [7:0]    fmtType, byteEn;
  logic [4:0]    shAmt;
  logic [DW-1:0] shiftedData, readPick;

  assign offWide    = 16'(reqOffset);
  assign rootHit    = (reqBus == rootBusQ);
  assign devNonZero = (reqDevFn[7:3] != 5'd0);
  assign shAmt      = {reqOffset[1:0], 3'b000};

  always_comb begin
    if (rootHit && reqDevFn == 8'd0 && offWide == BAR0_OFF)
      rejectCode = STS_BADREG;
    else if ((!rootHit && !linkUp) || (rootHit && devNonZero) ||
             (reqPrimaryBus == rootBusQ && devNonZero))
      rejectCode = STS_NOTFOUND;
    else
      rejectCode = STS_OK;
  end

  always_comb begin
    if (rootHit) fmtType = reqWrite ? FMT_WR_T0 : FMT_RD_T0;
    else         fmtType = reqWrite ? FMT_WR_T1 : FMT_RD_T1;
    case (reqSize)
      2'd0: begin
        byteEn      = 8'h01 << reqOffset[1:0];
        shiftedData = (reqWdata & 32'h0000_00FF) << shAmt;
      end
      2'd1: begin
        byteEn      = 8'h03 << reqOffset[1:0];
        shiftedData = (reqWdata & 32'h0000_FFFF) << shAmt;
      end
      default: begin
        byteEn      = 8'h0F;
        shiftedData = reqWdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdr0Q <= '0; hdr1Q <= '0; hdr2Q <= '0; payloadQ <= '0;
      writeQ <= 1'b0; rootCfgQ <= 1'b0; offLoQ <= '0; sizeQ <= '0;
      threeBeats <= 1'b0;
    end else if (stb.capture) begin
      hdr0Q      <= {fmtType, 24'd1};
      hdr1Q      <= {rootBusQ, 8'h00, reqWrite ? TAG_WR : TAG_RD, byteEn};
      hdr2Q      <= {reqBus, reqDevFn, offWide & 16'hFFFC};
      payloadQ   <= reqWrite ? shiftedData : '0;
      writeQ     <= reqWrite;
      rootCfgQ   <= rootHit && (offWide == PRIM_BUS_OFF);
      offLoQ     <= reqOffset[1:0];
      sizeQ      <= reqSize;
      threeBeats <= reqWrite && (reqOffset[2:0] == 3'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rootBusQ <= ROOT_RESET;
    else if (stb.loadCpl && writeQ && rootCfgQ && !cplError)
      rootBusQ <= payloadQ[7:0];
  end

  always_comb begin
    case (sizeQ)
      2'd0:    readPick = (cplData >> {offLoQ, 3'b000}) & 32'h0000_00FF;
      2'd1:    readPick = (cplData >> {offLoQ[1], 4'b0000}) & 32'h0000_FFFF;
      default: readPick = cplData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspStatusQ <= STS_OK;
      rspDataQ   <= '0;
    end else if (stb.loadReject) begin
      rspStatusQ <= rejectCode;
      rspDataQ   <= reqWrite ? '0 : '1;
    end else if (stb.loadCpl) begin
      rspStatusQ <= cplError ? STS_NOTFOUND : STS_OK;
      rspDataQ   <= writeQ ? '0 : (cplError ? '1 : readPick);
    end
  end

  assign rspStatus = rspStatusQ;
  assign rspData   = rspDataQ;

  always_comb begin
    beatSop  = 1'b0;
    beatEop  = 1'b0;
    case (stb.beatSel)
      2'd0: begin
        beatData = {hdr1Q, hdr0Q};
        beatSop  = 1'b1;
      end
      2'd1: begin
        beatData = threeBeats ? {{DW{1'b0}}, hdr2Q} : {payloadQ, hdr2Q};
        beatEop  = !threeBeats;
      end
      default: begin
        beatData = {{DW{1'b0}}, payloadQ};
        beatEop  = 1'b1;
      end
    endcase
  end

  // R8: the root bus copy only moves on a completion
  p_root_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCpl |=> $stable(rootBusQ));
endmodule

// File: rtl/cfg_pkt_builder.sv
module cfg_pkt_builder
  import cfgpkt_pkg::*;
#(
  parameter int         OFF_W      = 12,
  parameter logic [7:0] ROOT_RESET = 8'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  input  logic [7:0]        reqPrimaryBus,
  output logic              txValid,
  input  logic              txReady,
  output logic [63:0]       txData,
  output logic              txSop,
  output logic              txEop,
  input  logic              cplValid,
  input  logic              cplError,
  input  logic [31:0]       cplData,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [31:0]       rspData
);
  strobe_t    stb;
  logic [1:0] rejectCode;
  logic       threeBeats;
  logic       beatSop, beatEop;

  cfgpkt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rejectCode(rejectCode), .threeBeats(threeBeats), .txValid(txValid),
    .txReady(txReady), .cplValid(cplValid), .rspValid(rspValid), .stb(stb)
  );

  cfgpkt_datapath #(.OFF_W(OFF_W), .ROOT_RESET(ROOT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .linkUp(linkUp), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqPrimaryBus(reqPrimaryBus),
    .cplError(cplError), .cplData(cplData), .rejectCode(rejectCode),
    .threeBeats(threeBeats), .beatData(txData), .beatSop(beatSop),
    .beatEop(beatEop), .rspStatus(rspStatus), .rspData(rspData)
  );

  assign txSop = txValid && beatSop;
  assign txEop = txValid && beatEop;

  // R10: a stalled beat is held unchanged
  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txSop) && $stable(txEop)));

  // R5: no beat is both first and last
  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !(txSop && txEop));

  // R5: an accepted, unfiltered access opens with a start beat
  p_sop_after_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && rejectCode == STS_OK) |=> (txValid && txSop));
endmodule

// File: tb/cfg_pkt_builder_bench.sv
module cfg_pkt_builder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b1, reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqBus = '0, reqDevFn = '0, reqPrimaryBus = '0;
  logic [11:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0, cplData = '0;
  logic        txReady = 1'b1, cplValid = 1'b0, cplError = 1'b0;
  logic        reqReady, txValid, txSop, txEop, rspValid;
  logic [63:0] txData;
  logic [1:0]  rspStatus;
  logic [31:0] rspData;

  int checks = 0;
  int fails  = 0;
  logic [7:0] modelRoot = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_pkt_builder u_cfg_pkt_builder (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqPrimaryBus(reqPrimaryBus),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txSop(txSop), .txEop(txEop),
    .cplValid(cplValid), .cplError(cplError), .cplData(cplData),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspData(rspData)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runAccess(input logic w, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [11:0] off, input logic [1:0] size, input logic [31:0] wd,
                           input logic [7:0] prim, input logic link, input logic cErr,
                           input logic [31:0] cDat, input logic bp);
    logic [7:0]  fmt, be;
    logic [31:0] h0, h1, h2, pay, expData;
    logic [1:0]  expSts;
    int          expN, gotN, n;
    logic [63:0] expD [3];
    logic [1:0]  expF [3];
    logic [63:0] gotD [4];
    logic [1:0]  gotF [4];
    logic        got, eopSeen, sentCpl, sawReady;
    logic        rootHit, dev0;
    logic [31:0] sh;
    rootHit = (bus == modelRoot);
    dev0    = (devfn[7:3] == 5'd0);
    sh      = 32'(off[1:0]) * 8;
    fmt = rootHit ? (w ? 8'h44 : 8'h04) : (w ? 8'h45 : 8'h05);
    case (size)
      2'd0: begin be = 8'h01 << off[1:0]; pay = (wd & 32'hFF) << sh; end
      2'd1: begin be = 8'h03 << off[1:0]; pay = (wd & 32'hFFFF) << sh; end
      default: begin be = 8'h0F; pay = wd; end
    endcase
    h0 = {fmt, 24'd1};
    h1 = {modelRoot, 8'h00, w ? 8'h10 : 8'h1D, be};
    h2 = {bus, devfn, 4'h0, off[11:2], 2'b00};
    expN = 0;
    if (rootHit && devfn == 8'd0 && off == 12'h010) begin
      expSts = 2'd2; expData = w ? 32'h0 : 32'hFFFF_FFFF;
    end else if ((!rootHit && !link) || (rootHit && !dev0) || (prim == modelRoot && !dev0)) begin
      expSts = 2'd1; expData = w ? 32'h0 : 32'hFFFF_FFFF;
    end else begin
      expD[0] = {h1, h0}; expF[0] = 2'b10;
      if (w && off[2:0] == 3'd0) begin
        expN = 3;
        expD[1] = {32'h0, h2}; expF[1] = 2'b00;
        expD[2] = {32'h0, pay}; expF[2] = 2'b01;
      end else begin
        expN = 2;
        expD[1] = {w ? pay : 32'h0, h2}; expF[1] = 2'b01;
      end
      if (cErr) begin expSts = 2'd1; expData = w ? 32'h0 : 32'hFFFF_FFFF; end
      else begin
        expSts = 2'd0;
        if (w) expData = 32'h0;
        else case (size)
          2'd0: expData = (cDat >> sh) & 32'hFF;
          2'd1: expData = (cDat >> (32'(off[1]) * 16)) & 32'hFFFF;
          default: expData = cDat;
        endcase
      end
    end

    @(negedge clk);
    reqWrite = w; reqBus = bus; reqDevFn = devfn; reqOffset = off; reqSize = size;
    reqWdata = wd; reqPrimaryBus = prim; linkUp = link; cplError = cErr; cplData = cDat;
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    gotN = 0; got = 0; eopSeen = 0; sentCpl = 0; sawReady = 0; n = 0;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      cplValid = 1'b0;
      txReady  = bp ? n[0] : 1'b1;
      #1;
      if (rspValid) begin
        got = 1;
        check(rspStatus == expSts, "R6/R7/R10 status", 64'(rspStatus), 64'(expSts));
        check(rspData == expData, "R7/R10 data", 64'(rspData), 64'(expData));
      end else begin
        if (reqReady) sawReady = 1;
        if (txValid && txReady) begin
          if (gotN < 4) begin gotD[gotN] = txData; gotF[gotN] = {txSop, txEop}; end
          gotN++;
          if (txEop) eopSeen = 1;
        end else if (eopSeen && !sentCpl) begin
          cplValid = 1'b1; sentCpl = 1;
        end
      end
    end
    check(got, "R9 response arrives", 64'(got), 64'd1);
    check(!sawReady, "R9 reqReady low while busy", 64'(sawReady), 64'd0);
    check(gotN == expN, "R5/R6/R7 beat count", 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotD[i] == expD[i], "R1/R2/R3/R4/R5 beat data", gotD[i], expD[i]);
      check(gotF[i] == expF[i], "R5 beat flags", 64'(gotF[i]), 64'(expF[i]));
    end
    @(negedge clk); #1;
    check(!rspValid, "R9 one-cycle response", 64'(rspValid), 64'd0);
    txReady = 1'b1;
    if (w && expSts == 2'd0 && rootHit && off == 12'h018) modelRoot = pay[7:0];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R9 reset ready", 64'(reqReady), 64'd1);
    check(!txValid, "R5 reset idle tx", 64'(txValid), 64'd0);
    check(!rspValid, "R9 reset no response", 64'(rspValid), 64'd0);

    // R1 R2 R3 R4 R5 R10: Type 0 sweep over direction, size and offset in a quad-word
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 3; s++)
        for (int lo = 0; lo < 8; lo++)
          runAccess(w[0], 8'd0, 8'd0, 12'h040 + 12'(lo), s[1:0], 32'hA1B2_C3D4 + 32'(lo * 77),
                    8'd0, 1'b1, 1'b0, 32'h1122_3344 ^ 32'(lo << 9), lo[0]);

    // R1: Type 1 on non-root buses
    for (int w = 0; w < 2; w++)
      for (int lo = 0; lo < 8; lo += 4) begin
        runAccess(w[0], 8'd1, 8'd0, 12'h100 + 12'(lo), 2'd2, 32'hCAFE_0001, 8'd0, 1'b1, 1'b0, 32'h5566_7788, 1'b0);
        runAccess(w[0], 8'd5, 8'h13, 12'hFFC - 12'(lo), 2'd1, 32'h0000_BEEF, 8'd3, 1'b1, 1'b0, 32'h9ABC_DEF0, 1'b1);
      end

    // R6: BAR0 of the root port is refused; another function reaches it
    runAccess(1'b0, 8'd0, 8'd0, 12'h010, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b1, 8'd0, 8'd0, 12'h010, 2'd2, 32'hFFFF_FFFF, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd0, 8'd1, 12'h010, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h1234_5678, 1'b0);

    // R7: device filtering and link-down filtering
    runAccess(1'b0, 8'd0, 8'h08, 12'h000, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd1, 8'h08, 12'h000, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b1, 8'd2, 8'h00, 12'h004, 2'd2, 32'h7, 8'd1, 1'b0, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd2, 8'h00, 12'h004, 2'd0, 32'h0, 8'd1, 1'b0, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd0, 8'h00, 12'h008, 2'd2, 32'h0, 8'd0, 1'b0, 1'b0, 32'hDEAD_0000, 1'b0);

    // R10: completion errors
    runAccess(1'b0, 8'd0, 8'd0, 12'h020, 2'd2, 32'h0, 8'd0, 1'b1, 1'b1, 32'h1, 1'b0);
    runAccess(1'b1, 8'd1, 8'd0, 12'h022, 2'd1, 32'h55AA, 8'd0, 1'b1, 1'b1, 32'h0, 1'b1);

    // R8: root bus tracking, then accesses on old and new root bus
    runAccess(1'b1, 8'd0, 8'd0, 12'h018, 2'd2, 32'h0003_0201, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd1, 8'd0, 12'h000, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'hAAAA_5555, 1'b0);
    runAccess(1'b0, 8'd0, 8'd0, 12'h000, 2'd2, 32'h0, 8'd7, 1'b1, 1'b0, 32'h0F0F_F0F0, 1'b0);
    runAccess(1'b1, 8'd1, 8'd0, 12'h018, 2'd2, 32'h0000_0077, 8'd0, 1'b1, 1'b1, 32'h0, 1'b0);
    runAccess(1'b0, 8'd1, 8'h08, 12'h000, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b1, 8'd1, 8'd0, 12'h018, 2'd0, 32'hFFFF_FF09, 8'd0, 1'b1, 1'b0, 32'h0, 1'b1);
    runAccess(1'b0, 8'd9, 8'd0, 12'h010, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    runAccess(1'b0, 8'd1, 8'd0, 12'h010, 2'd2, 32'h0, 8'd0, 1'b1, 1'b0, 32'h3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule